// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts on its own slow clock, separate from the bus clock that software uses to reach it. A free-running divider on the slow clock produces count ticks, and each tick steps a down-counter. When a tick arrives while the counter already sits at zero, the block raises a one-cycle reset request on the slow clock, reloads the counter and carries on counting.

Software controls the block only through key values written to a key register. One key starts counting, another refreshes the counter from the reload value, and a third opens the divider-select and reload registers for writing. Any other key write closes them again, and so does the refresh key. New divider-select and reload values cross into the slow domain through a handshake. While a value is on its way, a status flag shows it as pending. Once counting has begun, no write of any kind can stop it.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the divider select reads 0, the reload reads 0xFFF, the status reads 0 and `wdg_rst` is low.
- R2: Writes to the divider select (address 1) or the reload (address 2) take effect only after key 0x5555 has been written to address 0. Any later key write of another value closes them again, and that includes the refresh key 0xAAAA.
- R3: Reads at address 1 return the 3-bit divider code in bits 2:0. Reads at address 2 return the 12-bit reload value in bits 11:0, and upper write bits are dropped. Reads at address 0 return 0.
- R4: Status at address 3 has bit 0 set while a divider update is pending and bit 1 set while a reload update is pending. A flag rises in the cycle after an accepted write and clears after the slow domain has taken the value. A write to a register whose flag is set is ignored.
- R5: Before key 0xCCCC is written, `wdg_rst` never rises.
- R6: Once started, with no refresh, reset pulses repeat every (reload+1)×division slow-clock cycles.
- R7: Divider codes 0 to 6 select division by 4, 8, 16, 32, 64, 128 and 256. Code 7 divides by 256.
- R8: Refreshes with key 0xAAAA that come faster than the timeout prevent every reset pulse.
- R9: Each reset pulse lasts exactly one slow-clock cycle. The counter then reloads and keeps running.
- R10: After start, no key or register write stops the watchdog.
- R11: A refresh taken in the same slow-clock cycle as an expiry wins, and no pulse is produced. Whether a pulse appears depends only on whether the refresh lands before or after the expiry edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| we | input | 1 | Write enable |
| addr | input | 2 | Register address: 0 key, 1 divider, 2 reload, 3 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| wclk | input | 1 | Slow watchdog clock |
| wdg_rst | output | 1 | Reset request, one slow-clock cycle wide |

## Verification
The refresh and the expiry can land on the same slow-clock edge. The bench provokes this by aligning to a reset pulse and then issuing a refresh at a sweep of offsets, one slow cycle apart, around the next expiry. For each offset it records whether a pulse appeared exactly one timeout after the previous one. It then checks that early offsets give no pulse, late offsets give one, and the outcome changes only once across the sweep, with no double or misplaced pulse at the crossover.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter logic [15:0] KEY_OPEN  = 16'h5555,
  parameter logic [15:0] KEY_FEED  = 16'hAAAA,
  parameter logic [15:0] KEY_START = 16'hCCCC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        wclk,
  output logic        wdg_rst
);
  // bus domain
  logic        unlocked, start_q, feed_tgl, pend_pr, pend_rl;
  logic [2:0]  pr_q;
  logic [11:0] rl_q;
  logic [1:0]  a1, a2;
  logic        ack_pr_w, ack_rl_w;

  wire key_wr = we && addr == 2'd0;
  wire pr_ok  = we && addr == 2'd1 && unlocked && !pend_pr && !a2[0];
  wire rl_ok  = we && addr == 2'd2 && unlocked && !pend_rl && !a2[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      unlocked <= 1'b0; start_q <= 1'b0; feed_tgl <= 1'b0;
      pend_pr <= 1'b0; pend_rl <= 1'b0;
      pr_q <= 3'd0; rl_q <= 12'hFFF; a1 <= 2'b0; a2 <= 2'b0;
    end else begin
      a1 <= {ack_rl_w, ack_pr_w};
      a2 <= a1;
      if (key_wr) begin
        unlocked <= (wdata == KEY_OPEN);
        if (wdata == KEY_START) start_q <= 1'b1;
        if (wdata == KEY_FEED) feed_tgl <= ~feed_tgl;
      end
      if (pr_ok) begin
        pr_q <= wdata[2:0]; pend_pr <= 1'b1;
      end else if (pend_pr && a2[0]) pend_pr <= 1'b0;
      if (rl_ok) begin
        rl_q <= wdata[11:0]; pend_rl <= 1'b1;
      end else if (pend_rl && a2[1]) pend_rl <= 1'b0;
    end

  always_comb
    case (addr)
      2'd1:    rdata = {13'd0, pr_q};
      2'd2:    rdata = {4'd0, rl_q};
      2'd3:    rdata = {14'd0, pend_rl | a2[1], pend_pr | a2[0]};
      default: rdata = 16'd0;
    endcase

  // watchdog domain
  logic [3:0]  s1, s2;
  logic        feed_d, started;
  logic [2:0]  pr_act;
  logic [11:0] rl_act, cnt;
  logic [7:0]  pcnt;
  logic [8:0]  pspan;
  logic [7:0]  pmask;

  wire feed_evt = s2[3] ^ feed_d;
  wire [2:0] psel = (pr_act > 3'd6) ? 3'd6 : pr_act;
  assign pspan = 9'd4 << psel;
  assign pmask = 8'(pspan - 9'd1);
  wire tick = (pcnt & pmask) == pmask;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 4'd0; s2 <= 4'd0; feed_d <= 1'b0;
      ack_pr_w <= 1'b0; ack_rl_w <= 1'b0;
      pr_act <= 3'd0; rl_act <= 12'hFFF;
      pcnt <= 8'd0; started <= 1'b0; cnt <= 12'hFFF; wdg_rst <= 1'b0;
    end else begin
      s1 <= {feed_tgl, start_q, pend_rl, pend_pr};
      s2 <= s1;
      feed_d <= s2[3];
      ack_pr_w <= s2[0];
      ack_rl_w <= s2[1];
      if (s2[0] && !ack_pr_w) pr_act <= pr_q;
      if (s2[1] && !ack_rl_w) rl_act <= rl_q;
      pcnt <= pcnt + 8'd1;
      wdg_rst <= 1'b0;
      if (!started) begin
        if (s2[2]) begin
          started <= 1'b1; cnt <= rl_act;
        end
      end else if (feed_evt) begin
        cnt <= rl_act;
      end else if (tick) begin
        if (cnt == 12'd0) begin
          wdg_rst <= 1'b1; cnt <= rl_act;
        end else cnt <= cnt - 12'd1;
      end
    end

  a_r9_one_cycle_pulse: assert property (@(posedge wclk) disable iff (!rst_n)
    wdg_rst |=> !wdg_rst);
  a_r10_never_stops: assert property (@(posedge wclk) disable iff (!rst_n)
    started |=> started);
  a_r5_quiet_before_start: assert property (@(posedge wclk) disable iff (!rst_n)
    !started |=> !wdg_rst);
  a_r11_feed_wins: assert property (@(posedge wclk) disable iff (!rst_n)
    (started && feed_evt) |=> !wdg_rst);
  a_r2_locked_divider: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd1 && !unlocked) |=> $stable(pr_q));
  a_r2_locked_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd2 && !unlocked) |=> $stable(rl_q));
  a_r4_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rl && !a2[1]) |=> pend_rl);
endmodule

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  logic clk = 1'b0, wclk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wdata = 16'd0, rdata;
  logic wdg_rst;
  int total = 0, bad = 0, pulses = 0;
  time last_t = 0;

  keyed_watchdog uut (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
                      .rdata(rdata), .wclk(wclk), .wdg_rst(wdg_rst));

  always #4 clk = ~clk;
  initial begin #2; forever #20 wclk = ~wclk; end
  always @(posedge wdg_rst) begin pulses++; last_t = $time; end

  // {key (0 = none), addr, data, expected readback}
  localparam logic [49:0] VEC [8] = '{
    {16'h0000, 2'd1, 16'h0003, 16'h0000},
    {16'h5555, 2'd1, 16'h0005, 16'h0005},
    {16'h0000, 2'd2, 16'hF009, 16'h0009},
    {16'h1234, 2'd2, 16'h0100, 16'h0009},
    {16'h5555, 2'd1, 16'h000F, 16'h0007},
    {16'hAAAA, 2'd1, 16'h0002, 16'h0007},
    {16'h5555, 2'd1, 16'h0000, 16'h0000},
    {16'h0000, 2'd0, 16'h5555, 16'h0000}};

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic settle();
    logic [15:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(2'd3, v);
      if (v == 16'd0) return;
    end
    chk("R4 pending clears", v, 0);
  endtask

  task automatic interval(output longint ns);
    time t0;
    @(posedge wdg_rst); t0 = $time;
    @(posedge wdg_rst); ns = longint'($time - t0);
  endtask

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    longint ns;
    int base, w;
    bit seen, prev;
    time t0;
    #30 rst_n = 1'b1;
    // R1 reset state
    rd(2'd1, v); chk("R1 divider", v, 0);
    rd(2'd2, v); chk("R1 reload", v, 16'hFFF);
    rd(2'd3, v); chk("R1 status", v, 0);
    chk("R1 wdg_rst", wdg_rst, 0);

    // table: lock, unlock, widths, relock
    foreach (VEC[i]) begin
      if (VEC[i][49:34] != 16'd0) wr(2'd0, VEC[i][49:34]);
      wr(VEC[i][33:32], VEC[i][31:16]);
      settle();
      rd(VEC[i][33:32], v);
      chk($sformatf("R2/R3 vector %0d", i), v, VEC[i][15:0]);
    end

    // R4 pending flag and blocked second write
    wr(2'd2, 16'h0004);
    rd(2'd3, v); chk("R4 reload pending bit1", v, 2);
    wr(2'd2, 16'h0007);
    settle();
    rd(2'd2, v); chk("R4 write while pending ignored", v, 4);
    wr(2'd0, 16'h5555); wr(2'd1, 16'h0000);
    rd(2'd3, v); chk("R4 divider pending bit0", v, 1);
    settle();
    wr(2'd2, 16'h0009); settle();
    rd(2'd2, v); chk("R3 reload 9", v, 9);

    // R5 no reset before start
    #3000; chk("R5 no pulse before start", pulses, 0);

    // R6 start and timeout
    wr(2'd0, 16'hCCCC);
    interval(ns); chk("R6 timeout div4 reload9", ns, 1600);
    // R9 width
    @(posedge wdg_rst); w = 0;
    while (wdg_rst) begin @(negedge clk); if (wdg_rst) w++; end
    chk("R9 pulse one wclk", w, 5);
    interval(ns); chk("R9 keeps running", ns, 1600);

    // R7 divider codes
    wr(2'd0, 16'h5555); wr(2'd1, 16'h0001); settle();
    @(posedge wdg_rst); interval(ns); chk("R7 code1 div8", ns, 3200);
    wr(2'd0, 16'h5555); wr(2'd1, 16'h0007); settle();
    @(posedge wdg_rst); interval(ns); chk("R7 code7 div256", ns, 102400);
    wr(2'd0, 16'h5555); wr(2'd1, 16'h0000); settle();
    @(posedge wdg_rst);

    // R8 refresh prevents reset
    wr(2'd0, 16'hAAAA); base = pulses;
    for (int k = 0; k < 20; k++) begin #780; wr(2'd0, 16'hAAAA); end
    chk("R8 refresh holds off reset", pulses, base);

    // R10 cannot be stopped
    wr(2'd0, 16'h0000); wr(2'd0, 16'h5555); wr(2'd0, 16'h1234);
    wr(2'd3, 16'h0000); wr(2'd0, 16'hCCCC); wr(2'd0, 16'hFFFF);
    interval(ns); chk("R10 still running", ns, 1600);

    // R11 refresh versus expiry sweep
    prev = 1'b0;
    for (int d = 30; d <= 44; d++) begin
      @(posedge wdg_rst); t0 = $time; #1 base = pulses;
      #(d * 40 + 3);
      wr(2'd0, 16'hAAAA);
      if ($time < t0 + 1608) #(t0 + 1608 - $time);
      seen = (pulses != base);
      if (seen) chk($sformatf("R11 pulse position d=%0d", d), longint'(last_t - t0), 1600);
      if (d == 30) chk("R11 early refresh no pulse", seen, 0);
      if (d == 44) chk("R11 late refresh pulse", seen, 1);
      if (prev && !seen) chk($sformatf("R11 monotonic d=%0d", d), seen, 1);
      prev = seen;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule